// File: doc/BRIEF.md
# Threshold Interrupt Qualifier

This block takes the digitized output of a voltage comparator, which is high while a monitored input sits below its trip level, and turns it into a clean active-low interrupt. The comparator flag is asynchronous, so it first passes through a synchronizer. A dip only raises the interrupt once it has lasted a programmable number of clock cycles. Once raised, the interrupt is held for a guaranteed minimum number of cycles. It also stays raised for as long as the input remains below threshold.

Two overrides act on the same output. While the power-valid input is low, the interrupt is held asserted whatever the comparator reports. A master reset request also forces the interrupt. When the request goes away, the interrupt stays asserted for the full minimum pulse time. All durations are parameters in clock cycles, so the same block serves any clock rate and any set of analog timing targets.

Top module: `irq_qualifier`

## Requirements
- R1: While `rst_n` is low, `irq_n` is 0 (asserted). After reset, it stays 0 as long as `pwr_ok` is 0.
- R2: While `pwr_ok` is 0, `irq_n` is 0 whatever `cmp_below` does. A fall of `pwr_ok` sampled at a clock edge drives `irq_n` to 0 right after that edge.
- R3: Suppose `pwr_ok` rises with `cmp_below` = 0 and `mst_req` = 0. Counting the first edge that samples `pwr_ok` high as edge 1, `irq_n` is still 0 after edge MIN_CYCLES-1 and returns to 1 after edge MIN_CYCLES.
- R4: `cmp_below` = 1 means the monitored input is below threshold. A below-threshold run shorter than QUAL_CYCLES consecutive clock cycles never asserts `irq_n`. Runs separated by a single above-threshold cycle do not add together.
- R5: If `cmp_below` is held at 1 for at least QUAL_CYCLES cycles, `irq_n` falls right after the edge SYNC_STAGES+QUAL_CYCLES+1. Edges are counted from the first edge that samples the new value as edge 1.
- R6: Each assertion of `irq_n` that starts from the released state lasts at least MIN_CYCLES cycles.
- R7: `irq_n` stays asserted while the qualified comparator state is below threshold. It is released on the first cycle where the minimum width has elapsed and the qualified state is above threshold. Take a below-threshold run of L ≥ QUAL_CYCLES cycles. The resulting pulse is max(MIN_CYCLES, L+1-QUAL_CYCLES) cycles wide.
- R8: `mst_req` = 1 forces `irq_n` to 0. It falls right after edge SYNC_STAGES+1. If the request lasts M cycles, `irq_n` stays asserted for M+MIN_CYCLES-1 cycles in total, which is MIN_CYCLES after the last synchronized request cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_ok | input | 1 | Supply-valid gate, synchronous to clk; 0 forces the interrupt |
| cmp_below | input | 1 | Asynchronous comparator flag, 1 = input below threshold |
| mst_req | input | 1 | Asynchronous master reset request, 1 = force interrupt |
| irq_n | output | 1 | Qualified interrupt, active low |

## Verification
The comparator path carries SYNC_STAGES synchronizer flops, the dwell filter register and the output register. Its result therefore appears after edge SYNC_STAGES+QUAL_CYCLES+1, counted from the first edge that sees the new input. The master request skips the filter and appears after edge SYNC_STAGES+1. A change on `pwr_ok` meets only the output register, so it shows after one edge. Inputs are driven on the falling clock edge, and the output is sampled on the falling edge after each rising edge. Each check therefore lands on an exact edge count: the bench records the index of the first asserted sample and the number of asserted samples, and compares both with the formulas in R5, R7 and R8.

// File: rtl/irq_qual_pkg.sv
package irq_qual_pkg;

   typedef enum logic {
      OUT_IDLE   = 1'b0,
      OUT_ACTIVE = 1'b1
   } out_state_e;

   // width of a counter that must reach n-1
   function automatic int cnt_width(input int n);
      return (n <= 2) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/iq_sync.sv
module iq_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   logic [STAGES-1:0][WIDTH-1:0] chain;

   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= d;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else        chain <= {chain[STAGES-2:0], d};
         end
      end
   endgenerate

   assign q = chain[STAGES-1];

endmodule

// File: rtl/iq_dwell_filter.sv
module iq_dwell_filter #(
   parameter int QUAL_CYCLES = 100
) (
   input  logic clk,
   input  logic rst_n,
   input  logic below,
   output logic qual
);

   generate
      if (QUAL_CYCLES == 1) begin : g_pass
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) qual <= 1'b0;
            else        qual <= below;
         end
      end else begin : g_count
         localparam int CW = irq_qual_pkg::cnt_width(QUAL_CYCLES);
         localparam logic [CW-1:0] LAST = CW'(QUAL_CYCLES - 1);
         logic [CW-1:0] run_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               run_q <= '0;
               qual  <= 1'b0;
            end else if (!below) begin
               run_q <= '0;
               qual  <= 1'b0;
            end else if (run_q == LAST) begin
               qual  <= 1'b1;
            end else begin
               run_q <= run_q + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/iq_pulse_stretch.sv
module iq_pulse_stretch
   import irq_qual_pkg::*;
#(
   parameter int MIN_CYCLES = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic qual,
   input  logic force_req,
   output logic active
);

   localparam int HW = cnt_width(MIN_CYCLES);
   localparam logic [HW-1:0] LAST = HW'(MIN_CYCLES - 1);

   out_state_e    state_q;
   logic [HW-1:0] hold_q;
   logic          hold_done;

   assign hold_done = (hold_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= OUT_ACTIVE;
         hold_q  <= '0;
      end else begin
         unique case (state_q)
            OUT_IDLE: begin
               if (qual || force_req) begin
                  state_q <= OUT_ACTIVE;
                  hold_q  <= '0;
               end
            end
            OUT_ACTIVE: begin
               if (force_req) begin
                  hold_q <= '0;
               end else if (hold_done) begin
                  if (!qual) state_q <= OUT_IDLE;
               end else begin
                  hold_q <= hold_q + 1'b1;
               end
            end
            default: state_q <= OUT_ACTIVE;
         endcase
      end
   end

   assign active = (state_q == OUT_ACTIVE);

endmodule

// File: rtl/irq_qualifier.sv
module irq_qualifier #(
   parameter int SYNC_STAGES = 2,
   parameter int QUAL_CYCLES = 100,
   parameter int MIN_CYCLES  = 500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_ok,
   input  logic cmp_below,
   input  logic mst_req,
   output logic irq_n
);

   generate
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("irq_qualifier: SYNC_STAGES must be at least 1");
      end
      if (QUAL_CYCLES < 1) begin : g_bad_qual
         $error("irq_qualifier: QUAL_CYCLES must be at least 1");
      end
      if (MIN_CYCLES < 1) begin : g_bad_min
         $error("irq_qualifier: MIN_CYCLES must be at least 1");
      end
   endgenerate

   logic [1:0] sync_out;
   logic       sync_below;
   logic       sync_mst;
   logic       dwell_qual;
   logic       force_req;
   logic       out_active;

   iq_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mst_req, cmp_below}),
      .q     (sync_out)
   );

   assign sync_below = sync_out[0];
   assign sync_mst   = sync_out[1];

   iq_dwell_filter #(
      .QUAL_CYCLES (QUAL_CYCLES)
   ) u_dwell (
      .clk   (clk),
      .rst_n (rst_n),
      .below (sync_below),
      .qual  (dwell_qual)
   );

   assign force_req = sync_mst | ~pwr_ok;

   iq_pulse_stretch #(
      .MIN_CYCLES (MIN_CYCLES)
   ) u_stretch (
      .clk       (clk),
      .rst_n     (rst_n),
      .qual      (dwell_qual),
      .force_req (force_req),
      .active    (out_active)
   );

   assign irq_n = ~out_active;

endmodule

// File: rtl/irq_qualifier_chk.sv
module irq_qualifier_chk #(
   parameter int QUAL_CYCLES = 100,
   parameter int MIN_CYCLES  = 500
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_ok,
   input logic irq_n,
   input logic below_s,
   input logic mst_s,
   input logic qual
);

   int   run_len;
   int   low_len;
   logic seen_high;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_len   <= 0;
         low_len   <= 0;
         seen_high <= 1'b0;
      end else begin
         if (!below_s)                run_len <= 0;
         else if (run_len < QUAL_CYCLES) run_len <= run_len + 1;
         if (irq_n)                   low_len <= 0;
         else if (low_len < MIN_CYCLES)  low_len <= low_len + 1;
         if (irq_n)                   seen_high <= 1'b1;
      end
   end

   // R2
   p_pwr_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_ok |=> !irq_n);

   // R4
   p_dwell_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(qual) |-> (run_len >= QUAL_CYCLES));

   // R5
   p_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_n) |-> ($past(qual) || $past(mst_s) || !$past(pwr_ok)));

   // R6
   p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen_high && $rose(irq_n)) |-> (low_len >= MIN_CYCLES));

   // R7
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && qual) |=> !irq_n);

   // R8
   p_master_r8: assert property (@(posedge clk) disable iff (!rst_n)
      mst_s |=> !irq_n);

endmodule

bind irq_qualifier irq_qualifier_chk #(
   .QUAL_CYCLES (QUAL_CYCLES),
   .MIN_CYCLES  (MIN_CYCLES)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .pwr_ok  (pwr_ok),
   .irq_n   (irq_n),
   .below_s (sync_below),
   .mst_s   (sync_mst),
   .qual    (dwell_qual)
);

// File: tb/tb_irq_qualifier.sv
module tb_irq_qualifier;

   localparam int SYNC = 2;
   localparam int QUAL = 6;
   localparam int MINW = 10;
   localparam int WIN  = 60;
   localparam int NVEC = 9;

   // kind 0 = comparator dip, 1 = master request
   localparam int VKIND [NVEC] = '{0, 0, 0, 0, 0, 0, 0, 1, 1};
   localparam int VLEN  [NVEC] = '{1, 5, 6, 10, 15, 16, 30, 1, 8};

   function automatic int exp_first(input int kind, input int len);
      if (kind == 1) return SYNC + 1;                 // R8
      return (len >= QUAL) ? SYNC + QUAL + 1 : 0;     // R5 / R4
   endfunction

   function automatic int exp_width(input int kind, input int len);
      if (kind == 1) return len + MINW - 1;           // R8
      if (len < QUAL) return 0;                       // R4
      return (MINW > len + 1 - QUAL) ? MINW : len + 1 - QUAL;  // R7
   endfunction

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_ok = 1'b0;
   logic cmp_below = 1'b0;
   logic mst_req = 1'b0;
   logic irq_n;

   int n_checks = 0;
   int n_fail   = 0;
   int cyc      = 0;

   always #10 clk = ~clk;

   irq_qualifier #(
      .SYNC_STAGES (SYNC),
      .QUAL_CYCLES (QUAL),
      .MIN_CYCLES  (MINW)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_ok    (pwr_ok),
      .cmp_below (cmp_below),
      .mst_req   (mst_req),
      .irq_n     (irq_n)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         n_fail = n_fail + 1;
         $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 20000", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
         $finish;
      end
   end

   task automatic check(input string req, input int actual, input int expected);
      n_checks = n_checks + 1;
      if (actual != expected) begin
         n_fail = n_fail + 1;
         $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // drive one vector on the falling edge, sample after every rising edge
   task automatic run_vec(input int kind, input int len, output int first, output int width);
      first = 0;
      width = 0;
      for (int k = 0; k <= WIN; k++) begin
         @(negedge clk);
         if (k > 0 && irq_n == 1'b0) begin
            if (first == 0) first = k;
            width = width + 1;
         end
         cmp_below = (kind == 0) && (k < len);
         mst_req   = (kind == 1) && (k < len);
      end
   endtask

   initial begin
      int f;
      int w;
      // R1: reset state
      idle(3);
      check("R1 reset irq_n", irq_n, 0);
      @(negedge clk) rst_n = 1'b1;
      idle(5);
      check("R1 after reset, power not valid", irq_n, 0);

      // R2: comparator activity ignored while power not valid
      for (int i = 0; i < 12; i++) begin
         @(negedge clk) cmp_below = i[0];
      end
      @(negedge clk) cmp_below = 1'b0;
      idle(20);
      check("R2 gate holds irq_n", irq_n, 0);

      // R3: release MINW edges after pwr_ok rises
      pwr_ok = 1'b1;
      for (int k = 1; k <= MINW; k++) begin
         @(negedge clk);
         if (k == MINW - 1) check("R3 still asserted", irq_n, 0);
         if (k == MINW)     check("R3 released", irq_n, 1);
      end
      idle(5);

      // vector table: R4 R5 R6 R7 R8
      for (int v = 0; v < NVEC; v++) begin
         check("R7 idle before vector", irq_n, 1);
         run_vec(VKIND[v], VLEN[v], f, w);
         check((VKIND[v] == 1) ? "R8 first low" : "R5 first low", f, exp_first(VKIND[v], VLEN[v]));
         check((VKIND[v] == 1) ? "R8 width" : "R6 R7 width", w, exp_width(VKIND[v], VLEN[v]));
         idle(5);
      end

      // R4: two short runs split by one above-threshold cycle
      w = 0;
      for (int k = 0; k <= 40; k++) begin
         @(negedge clk);
         if (k > 0 && irq_n == 1'b0) w = w + 1;
         cmp_below = (k < QUAL - 1) || (k >= QUAL && k < 2 * QUAL - 1);
      end
      check("R4 split dips ignored", w, 0);

      // R2: power drop asserts after one edge
      @(negedge clk) pwr_ok = 1'b0;
      @(negedge clk);
      check("R2 power drop", irq_n, 0);
      pwr_ok = 1'b1;
      idle(MINW + 3);
      check("R3 release after power return", irq_n, 1);

      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

endmodule